// File: doc/BRIEF.md
# Single-Address Fly-By DMA Channel

This block is one DMA channel that moves data between a peripheral and external memory (or a memory-mapped peripheral) without ever holding the data. The peripheral is addressed only by an acknowledge strobe, and the memory side only by the address the channel drives. In each transfer, both of them see a single bus cycle together. Data goes straight across the external data bus, from whichever side drives it to the side that captures it.

Software first loads a memory address, a transfer count and a control word. The control word holds a 4-bit direction code, an address step mode and an enable bit. After that, the peripheral paces the channel with a level-sensitive request line. Each accepted request produces exactly one two-phase bus cycle, and a ready input can stretch that cycle. The channel steps the address and decrements the count after each cycle. It stops itself when the count runs out. It refuses to run when the direction code is not one it supports.

Top module: `flyby_dma_chan`

## Requirements
- R1: After reset, `dack`, `bus_rd`, `bus_wr`, `chan_en`, `done` and `addr_err` are all low.
- R2: No bus cycle starts unless `dreq` was high at the clock edge that began it. An enabled channel with `dreq` low stays quiet.
- R3: When `dreq` is sampled high while the channel is idle, enabled, legal and has a nonzero count, `dack` goes high on that edge. `dack` and the memory address on `bus_addr` are then driven together for the whole bus cycle, and the address holds steady throughout.
- R4: Control bits [3:0] select the direction. Code 4'b0010 means the peripheral drives data and memory is written, so `bus_wr` is high and `bus_rd` is low during the cycle. Code 4'b0011 means memory is read and the peripheral captures the data, so `bus_rd` is high and `bus_wr` is low.
- R5: A bus cycle lasts two clocks (setup, then data) when `bus_ready` is high. Each clock in which `bus_ready` is low during the data phase adds one clock, with all bus outputs held.
- R6: Control bits [5:4] choose the address step applied after each transfer: 2'b01 adds UNIT, 2'b10 subtracts UNIT, and 2'b00 or 2'b11 leave the address unchanged. The address wraps modulo 2^ADDR_W.
- R7: Each transfer decrements the count. At the end of the transfer that takes the count to zero, `chan_en` clears and `done` rises, and no further cycle starts even if `dreq` stays high.
- R8: A level request that is held high yields one transfer per request. At least one idle clock with `dack` low separates consecutive bus cycles.
- R9: If the channel is enabled with any code other than 4'b0010 or 4'b0011, it runs no bus cycle. It sets `addr_err` and clears `chan_en`.
- R10: Register writes (`reg_sel` 0 = address, 1 = count, 2 = control, with control bit 8 as enable) are ignored while a bus cycle is in progress.
- R11: If the channel is enabled with a count of zero, it runs no bus cycle. It raises `done` and clears `chan_en`.
- R12: Writing the control register clears `done` and `addr_err` on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| reg_wdata | input | DATA_W | Register write data |
| dreq | input | 1 | Peripheral transfer request, level |
| dack | output | 1 | Peripheral acknowledge, selects the peripheral |
| bus_addr | output | ADDR_W | Memory address |
| bus_rd | output | 1 | Memory read strobe |
| bus_wr | output | 1 | Memory write strobe |
| bus_ready | input | 1 | Bus ready; low in the data phase inserts a wait |
| chan_en | output | 1 | Channel enable state |
| done | output | 1 | Transfer count exhausted |
| addr_err | output | 1 | Illegal direction code was refused |

## Verification
The bench builds the channel with ADDR_W=16, CNT_W=8 and UNIT=4. With a 16-bit address, both wraparound directions (0x0008 stepping down past zero, and 0xFFFC stepping up) can be reached in a few transfers. The 8-bit count keeps each run short, while wait states up to two clocks and mid-cycle register writes still fit inside a single stimulus table entry.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_DATA  = 2'd2
  } seq_state_e;

  localparam logic [3:0] RS_DEV_TO_MEM = 4'b0010;
  localparam logic [3:0] RS_MEM_TO_DEV = 4'b0011;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  localparam logic [1:0] STEP_HOLD = 2'b00;
  localparam logic [1:0] STEP_UP   = 2'b01;
  localparam logic [1:0] STEP_DOWN = 2'b10;

  // Only the two fly-by pairings are legal direction codes.
  function automatic logic rs_is_legal(input logic [3:0] rs);
    return (rs == RS_DEV_TO_MEM) || (rs == RS_MEM_TO_DEV);
  endfunction

  // Next memory address after one transfer; the caller truncates.
  function automatic logic [31:0] step_addr(input logic [31:0] a,
                                            input logic [1:0]  mode,
                                            input logic [31:0] unit);
    case (mode)
      STEP_UP:   return a + unit;
      STEP_DOWN: return a - unit;
      default:   return a;
    endcase
  endfunction

endpackage

// File: rtl/fbd_addr_cnt.sv
module fbd_addr_cnt
  import flyby_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int UNIT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_addr,
  input  logic              ld_count,
  input  logic [ADDR_W-1:0] wdata_addr,
  input  logic [CNT_W-1:0]  wdata_cnt,
  input  logic [1:0]        step_mode,
  input  logic              ev_xfer_end,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              cnt_is_zero,
  output logic              cnt_is_one
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_nxt;
  logic [31:0]       addr_wide;

  always_comb begin
    addr_wide = step_addr(32'(mem_addr), step_mode, 32'(UNIT));
    addr_nxt  = addr_wide[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr <= '0;
      cnt_q    <= '0;
    end else begin
      if (ld_addr)
        mem_addr <= wdata_addr;
      else if (ev_xfer_end)
        mem_addr <= addr_nxt;
      if (ld_count)
        cnt_q <= wdata_cnt;
      else if (ev_xfer_end)
        cnt_q <= cnt_q - CNT_ONE;
    end
  end

  assign cnt_is_zero = (cnt_q == '0);
  assign cnt_is_one  = (cnt_q == CNT_ONE);

endmodule

// File: rtl/fbd_cfg_regs.sv
module fbd_cfg_regs
  import flyby_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_ctrl,
  input  logic [3:0] wdata_rs,
  input  logic [1:0] wdata_step,
  input  logic       wdata_en,
  input  logic       ev_last,
  input  logic       ev_refuse_code,
  input  logic       ev_refuse_zero,
  output logic [3:0] rs_code,
  output logic [1:0] step_mode,
  output logic       chan_en,
  output logic       done,
  output logic       addr_err
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_code   <= '0;
      step_mode <= STEP_HOLD;
      chan_en   <= 1'b0;
      done      <= 1'b0;
      addr_err  <= 1'b0;
    end else if (ld_ctrl) begin
      rs_code   <= wdata_rs;
      step_mode <= wdata_step;
      chan_en   <= wdata_en;
      done      <= 1'b0;
      addr_err  <= 1'b0;
    end else begin
      if (ev_last || ev_refuse_zero) begin
        chan_en <= 1'b0;
        done    <= 1'b1;
      end
      if (ev_refuse_code) begin
        chan_en  <= 1'b0;
        addr_err <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fbd_seq.sv
module fbd_seq
  import flyby_dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dreq,
  input  logic bus_ready,
  input  logic hold,
  input  logic chan_en,
  input  logic rs_ok,
  input  logic cnt_is_zero,
  input  logic cnt_is_one,
  output logic cyc_active,
  output logic in_data,
  output logic ev_start,
  output logic ev_refuse_code,
  output logic ev_refuse_zero,
  output logic ev_xfer_end,
  output logic ev_last
);

  seq_state_e st_q, st_d;
  logic       idle_ok;

  assign idle_ok        = (st_q == ST_IDLE) && chan_en && !hold;
  assign ev_refuse_code = idle_ok && !rs_ok;
  assign ev_refuse_zero = idle_ok && rs_ok && cnt_is_zero;
  assign ev_start       = idle_ok && rs_ok && !cnt_is_zero && dreq;
  assign in_data        = (st_q == ST_DATA);
  assign ev_xfer_end    = in_data && bus_ready;
  assign ev_last        = ev_xfer_end && cnt_is_one;
  assign cyc_active     = (st_q != ST_IDLE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (ev_start) st_d = ST_SETUP;
      ST_SETUP: st_d = ST_DATA;
      ST_DATA:  if (bus_ready) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/flyby_dma_chan.sv
module flyby_dma_chan
  import flyby_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int UNIT   = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              dreq,
  output logic              dack,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  input  logic              bus_ready,
  output logic              chan_en,
  output logic              done,
  output logic              addr_err
);

  logic       wr_ok;
  logic       ld_addr, ld_count, ld_ctrl;
  logic [3:0] rs_code;
  logic [1:0] step_mode;
  logic       cnt_is_zero, cnt_is_one;
  logic       cyc_active, in_data;
  logic       ev_start, ev_refuse_code, ev_refuse_zero, ev_xfer_end, ev_last;
  logic       unused_wdata;

  assign wr_ok    = reg_wr && !cyc_active;
  assign ld_addr  = wr_ok && (reg_sel == SEL_ADDR);
  assign ld_count = wr_ok && (reg_sel == SEL_COUNT);
  assign ld_ctrl  = wr_ok && (reg_sel == SEL_CTRL);
  assign unused_wdata = ^reg_wdata;

  fbd_addr_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .UNIT(UNIT)) addr_cnt_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_addr     (ld_addr),
    .ld_count    (ld_count),
    .wdata_addr  (reg_wdata[ADDR_W-1:0]),
    .wdata_cnt   (reg_wdata[CNT_W-1:0]),
    .step_mode   (step_mode),
    .ev_xfer_end (ev_xfer_end),
    .mem_addr    (bus_addr),
    .cnt_is_zero (cnt_is_zero),
    .cnt_is_one  (cnt_is_one)
  );

  fbd_cfg_regs cfg_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ld_ctrl        (ld_ctrl),
    .wdata_rs       (reg_wdata[3:0]),
    .wdata_step     (reg_wdata[5:4]),
    .wdata_en       (reg_wdata[8]),
    .ev_last        (ev_last),
    .ev_refuse_code (ev_refuse_code),
    .ev_refuse_zero (ev_refuse_zero),
    .rs_code        (rs_code),
    .step_mode      (step_mode),
    .chan_en        (chan_en),
    .done           (done),
    .addr_err       (addr_err)
  );

  fbd_seq seq_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .dreq           (dreq),
    .bus_ready      (bus_ready),
    .hold           (reg_wr),
    .chan_en        (chan_en),
    .rs_ok          (rs_is_legal(rs_code)),
    .cnt_is_zero    (cnt_is_zero),
    .cnt_is_one     (cnt_is_one),
    .cyc_active     (cyc_active),
    .in_data        (in_data),
    .ev_start       (ev_start),
    .ev_refuse_code (ev_refuse_code),
    .ev_refuse_zero (ev_refuse_zero),
    .ev_xfer_end    (ev_xfer_end),
    .ev_last        (ev_last)
  );

  assign dack   = cyc_active;
  assign bus_rd = cyc_active && (rs_code == RS_MEM_TO_DEV);
  assign bus_wr = cyc_active && (rs_code == RS_DEV_TO_MEM);

endmodule

// File: rtl/flyby_dma_chk.sv
module flyby_dma_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dreq,
  input logic              dack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_ready,
  input logic              chan_en,
  input logic              done,
  input logic              addr_err,
  input logic              in_data,
  input logic              ev_xfer_end,
  input logic              ev_last,
  input logic              ev_refuse_code
);

  AST_START_NEEDS_DREQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dack) |-> $past(dreq)); // R2

  AST_ADDR_HELD_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dack && $past(dack)) |-> $stable(bus_addr)); // R3

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (bus_rd ^ bus_wr)); // R4

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dack |-> (!bus_rd && !bus_wr)); // R4

  AST_WAIT_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !bus_ready) |=> (dack && $stable(bus_addr))); // R5

  AST_LAST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> (done && !chan_en)); // R7

  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer_end |=> !dack); // R8

  AST_ILLEGAL_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refuse_code |=> (addr_err && !chan_en && !dack)); // R9

endmodule

bind flyby_dma_chan flyby_dma_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .dreq           (dreq),
  .dack           (dack),
  .bus_addr       (bus_addr),
  .bus_rd         (bus_rd),
  .bus_wr         (bus_wr),
  .bus_ready      (bus_ready),
  .chan_en        (chan_en),
  .done           (done),
  .addr_err       (addr_err),
  .in_data        (in_data),
  .ev_xfer_end    (ev_xfer_end),
  .ev_last        (ev_last),
  .ev_refuse_code (ev_refuse_code)
);

// File: tb/flyby_dma_chan_tb_top.sv
module flyby_dma_chan_tb_top;

  localparam int AW = 16;
  localparam int CW = 8;
  localparam int UN = 4;

  typedef struct packed {
    logic [3:0]  code;
    logic [1:0]  step;
    logic [15:0] base;
    logic [7:0]  cnt;
    logic [3:0]  waits;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{code: 4'b0010, step: 2'b01, base: 16'h0100, cnt: 8'd3, waits: 4'd0},
    '{code: 4'b0011, step: 2'b10, base: 16'h0008, cnt: 8'd4, waits: 4'd1},
    '{code: 4'b0010, step: 2'b00, base: 16'h1234, cnt: 8'd2, waits: 4'd2},
    '{code: 4'b0011, step: 2'b11, base: 16'hFFF8, cnt: 8'd2, waits: 4'd0},
    '{code: 4'b0011, step: 2'b01, base: 16'hFFFC, cnt: 8'd2, waits: 4'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic [31:0]   reg_wdata = '0;
  logic          dreq = 1'b0;
  logic          bus_ready = 1'b1;
  logic          dack, bus_rd, bus_wr, chan_en, done, addr_err;
  logic [AW-1:0] bus_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flyby_dma_chan #(.ADDR_W(AW), .CNT_W(CW), .UNIT(UN), .DATA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dreq(dreq), .dack(dack), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ready(bus_ready),
    .chan_en(chan_en), .done(done), .addr_err(addr_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [15:0] want_addr(input logic [15:0] base,
                                            input logic [1:0] st, input int i);
    logic [15:0] off;
    off = 16'(i * UN);
    if (st == 2'b01)      return base + off;
    else if (st == 2'b10) return base - off;
    else                  return base;
  endfunction

  // Observe one bus cycle starting from a negedge; drives bus_ready for w waits.
  task automatic obs_xfer(input int w, output logic [15:0] a, output logic wr,
                          output logic rd, output int len, output int gap,
                          output int unstable);
    gap = 0; unstable = 0;
    while (!dack && gap < 30) begin
      gap++;
      @(negedge clk);
    end
    a = bus_addr; wr = bus_wr; rd = bus_rd; len = 0;
    while (dack && len < 40) begin
      len++;
      if (bus_addr != a || bus_wr != wr || bus_rd != rd) unstable++;
      bus_ready = (len >= w + 2);
      @(negedge clk);
    end
    bus_ready = 1'b1;
  endtask

  task automatic quiet(input int n, output int seen);
    seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (dack || bus_rd || bus_wr) seen++;
    end
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] a;
    logic wr, rd;
    int len, gap, unst, seen;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk({dack, bus_rd, bus_wr, chan_en, done, addr_err} == 6'b0, "R1",
        {26'b0, dack, bus_rd, bus_wr, chan_en, done, addr_err}, 32'h0);

    foreach (VEC[v]) begin
      wr_reg(2'd0, {16'h0, VEC[v].base});
      wr_reg(2'd1, {24'h0, VEC[v].cnt});
      wr_reg(2'd2, {23'h0, 1'b1, 2'b00, VEC[v].step, VEC[v].code});
      // R12: control write clears done
      chk(!done && !addr_err && chan_en, "R12", {30'b0, done, addr_err}, 32'h0);
      // R2: enabled but no request => no bus activity
      quiet(4, seen);
      chk(seen == 0, "R2", seen, 0);
      @(negedge clk);
      dreq = 1'b1;
      for (int t = 0; t < int'(VEC[v].cnt); t++) begin
        obs_xfer(int'(VEC[v].waits), a, wr, rd, len, gap, unst);
        // R3 / R6: address driven with dack, stepped per mode
        chk(a == want_addr(VEC[v].base, VEC[v].step, t), "R3 R6 address",
            {16'h0, a}, {16'h0, want_addr(VEC[v].base, VEC[v].step, t)});
        // R4: strobe matches direction code
        chk(wr == (VEC[v].code == 4'b0010) && rd == (VEC[v].code == 4'b0011),
            "R4 strobe", {30'b0, wr, rd},
            {30'b0, VEC[v].code == 4'b0010, VEC[v].code == 4'b0011});
        // R5: cycle length 2 + waits with held outputs
        chk(len == int'(VEC[v].waits) + 2 && unst == 0, "R5 length",
            len, int'(VEC[v].waits) + 2);
        // R8: one idle clock between cycles of a held request
        if (t > 0) chk(gap == 1, "R8 gap", gap, 1);
      end
      // R7: count exhausted => stop, done, enable cleared
      quiet(5, seen);
      chk(seen == 0 && done && !chan_en, "R7 stop",
          {seen[29:0], done, chan_en}, 32'h2);
      dreq = 1'b0;
    end

    // R9: illegal direction code refused
    wr_reg(2'd1, 32'd3);
    wr_reg(2'd2, {23'h0, 1'b1, 8'h15});
    dreq = 1'b1;
    quiet(4, seen);
    chk(seen == 0 && addr_err && !chan_en, "R9 illegal",
        {seen[29:0], addr_err, chan_en}, 32'h2);
    dreq = 1'b0;

    // R11 and R12: zero count refused; control write clears addr_err
    wr_reg(2'd1, 32'd0);
    wr_reg(2'd2, {23'h0, 1'b1, 8'h02});
    chk(!addr_err && !done, "R12 clear", {30'b0, addr_err, done}, 32'h0);
    dreq = 1'b1;
    quiet(4, seen);
    chk(seen == 0 && done && !chan_en, "R11 zero count",
        {seen[29:0], done, chan_en}, 32'h2);
    dreq = 1'b0;

    // R10: address write during a bus cycle is ignored
    wr_reg(2'd0, 32'h0400);
    wr_reg(2'd1, 32'd2);
    wr_reg(2'd2, {23'h0, 1'b1, 8'h13});
    @(negedge clk);
    bus_ready = 1'b0;
    dreq = 1'b1;
    for (int k = 0; k < 10 && !dack; k++) @(negedge clk);
    chk(dack && bus_addr == 16'h0400, "R3 start", {16'h0, bus_addr}, 32'h0400);
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h7777;
    @(negedge clk);
    reg_wr = 1'b0;
    @(negedge clk);
    chk(dack && bus_addr == 16'h0400, "R10 held", {16'h0, bus_addr}, 32'h0400);
    bus_ready = 1'b1;
    for (int k = 0; k < 10 && dack; k++) @(negedge clk);
    obs_xfer(0, a, wr, rd, len, gap, unst);
    chk(a == 16'h0404 && rd && !wr, "R10 ignored", {16'h0, a}, 32'h0404);
    dreq = 1'b0;
    quiet(3, seen);
    chk(done && seen == 0, "R7 after R10", {31'b0, done}, 32'h1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule